// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port Controller

This block controls one port of general-purpose pins for a small microcontroller core. Each pin has one bit in a data latch and one bit in each of two mode registers. Together the two mode bits choose one of four pin behaviours: quasi-bidirectional, push-pull, input-only or open-drain. For every pin the block produces four pad enables: a strong pull-down, a strong pull-up, a weak pull-up and a very weak pull-up. It also synchronizes the pad input so that the core can read it.

In quasi-bidirectional mode a pin acts as input and output at once. A latched 1 holds the pad high only weakly, so an external device can pull it low. When the latch goes from 0 to 1, the strong pull-up turns on for a short window so that the line rises quickly. A global input forces off the very weak pull-ups of all quasi-bidirectional pins.

The core writes registers through a valid/ready write channel. Ready is always high, so the block never applies back-pressure. A beat is accepted on every rising edge where valid is high, and the written register takes the new value on that edge. Two read outputs give the synchronized pad levels and the latch contents. The latch read serves read-modify-write sequences.

Top module: `gpq_port`

## Requirements
- R1: Each pin's mode is {mode1 bit, mode0 bit}. 00 is quasi-bidirectional, 10 is push-pull, 01 is input-only and 11 is open-drain.
- R2: A write is accepted on every rising edge where `wr_valid` is high, and `wr_ready` is always 1. Address 0 selects the data latch, address 1 selects mode register 0 and address 2 selects mode register 1. The new value is visible right after that edge.
- R3: Reset sets the latch to all ones and mode register 1 to all zeros. If `rst_tristate` is 1, mode register 0 resets to all ones (input-only). If it is 0, mode register 0 resets to zeros (quasi-bidirectional).
- R4: `en_pd` is high for a pin exactly when its latch bit is 0 and the pin is not input-only. A pin never has the pull-down and any pull-up enabled together.
- R5: `en_pu_vweak` is high exactly when the pin is quasi-bidirectional, its latch bit is 1 and `vwk_off` is 0.
- R6: `en_pu_weak` is high exactly when the pin is quasi-bidirectional, its latch bit is 1 and its synchronized pad level is 1.
- R7: In quasi-bidirectional mode, a latch bit rising from 0 to 1 turns on `en_pu_strong` for exactly BOOST_CYC cycles (2 by default), starting in the cycle the latch holds 1.
- R8: In push-pull mode, `en_pu_strong` equals the latch bit.
- R9: Open-drain pins never enable a pull-up. Input-only pins enable no driver at all.
- R10: `rd_pins` is `pad_in` delayed by SYNC_STAGES register stages (2 by default). `rd_latch` shows the latch contents.
- R11: A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_tristate | input | 1 | Reset-mode select: 1 gives input-only pins, 0 gives quasi-bidirectional pins |
| vwk_off | input | 1 | Global disable for the very weak pull-ups |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready (always 1) |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pad_in | input | 8 | Pad input levels |
| rd_pins | output | 8 | Synchronized pad levels |
| rd_latch | output | 8 | Data latch contents |
| en_pd | output | 8 | Strong pull-down enables |
| en_pu_strong | output | 8 | Strong pull-up enables |
| en_pu_weak | output | 8 | Weak pull-up enables |
| en_pu_vweak | output | 8 | Very weak pull-up enables |

## Verification
The bench builds the block with its default parameters: eight pins, a two-stage synchronizer and a two-cycle strong pull-up window. With eight pins, one mode-register pair places all four modes on different pins at the same time. The two-cycle window is long enough to observe both its start and its end, and to see it restart when the latch goes 1-0-1. The two-stage delay lets pad changes race the weak pull-up by a known number of cycles. Both reset-mode settings are applied.

// File: rtl/gpq_pkg.sv
package gpq_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_LATCH = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE0 = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE1 = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_SPARE = 2'd3;

  // encoding is {mode1 bit, mode0 bit}
  typedef enum logic [1:0] {
    MODE_QUASI = 2'b00,
    MODE_INPUT = 2'b01,
    MODE_PUSH  = 2'b10,
    MODE_DRAIN = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpq_regs.sv
module gpq_regs
  import gpq_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rst_tristate,
  input  logic                  wr_valid,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [PIN_W-1:0]      wr_data,
  output logic [PIN_W-1:0]      latch_q,
  output logic [PIN_W-1:0]      mode0_q,
  output logic [PIN_W-1:0]      mode1_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      mode0_q <= rst_tristate ? '1 : '0;
      mode1_q <= '0;
    end else if (wr_valid) begin
      case (wr_addr)
        ADDR_LATCH: latch_q <= wr_data;
        ADDR_MODE0: mode0_q <= wr_data;
        ADDR_MODE1: mode1_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R2
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADDR_LATCH) |=> (latch_q == $past(wr_data)));

  // R11
  spare_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == ADDR_SPARE) |=>
      ($stable(latch_q) && $stable(mode0_q) && $stable(mode1_q)));

endmodule

// File: rtl/gpq_sync.sv
module gpq_sync #(
  parameter int PIN_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pad_in,
  output logic [PIN_W-1:0] pad_sync
);

  logic [PIN_W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pad_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign pad_sync = stg[STAGES-1];

endmodule

// File: rtl/gpq_pin.sv
module gpq_pin
  import gpq_pkg::*;
#(
  parameter int BOOST_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m0,
  input  logic m1,
  input  logic latch_bit,
  input  logic pad_bit,
  input  logic vwk_off,
  output logic en_pd,
  output logic en_strong,
  output logic en_weak,
  output logic en_vweak
);

  localparam int CW = $clog2(BOOST_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BOOST_CYC - 1);

  pin_mode_e mode;
  logic prev_q, rise, boost;
  logic [CW-1:0] cnt_q;

  assign mode  = pin_mode_e'({m1, m0});
  assign rise  = latch_bit & ~prev_q;
  assign boost = rise | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= latch_bit;
      if (rise && mode == MODE_QUASI) cnt_q <= LOAD;
      else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    en_pd     = 1'b0;
    en_strong = 1'b0;
    en_weak   = 1'b0;
    en_vweak  = 1'b0;
    case (mode)
      MODE_QUASI: begin
        en_pd     = ~latch_bit;
        en_strong = latch_bit & boost;
        en_weak   = latch_bit & pad_bit;
        en_vweak  = latch_bit & ~vwk_off;
      end
      MODE_PUSH: begin
        en_pd     = ~latch_bit;
        en_strong = latch_bit;
      end
      MODE_DRAIN: en_pd = ~latch_bit;
      default: ;
    endcase
  end

  // R4
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_pd |-> !(en_strong || en_weak || en_vweak));

  // R9
  input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INPUT) |-> !(en_pd || en_strong || en_weak || en_vweak));

  // R9
  drain_nopull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DRAIN) |-> !(en_strong || en_weak || en_vweak));

  // R5
  vweak_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vwk_off |-> !en_vweak);

  // R7
  boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_QUASI && $rose(latch_bit)) |-> en_strong);

endmodule

// File: rtl/gpq_port.sv
module gpq_port
  import gpq_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BOOST_CYC   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rst_tristate,
  input  logic                  vwk_off,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [PIN_W-1:0]      wr_data,
  input  logic [PIN_W-1:0]      pad_in,
  output logic [PIN_W-1:0]      rd_pins,
  output logic [PIN_W-1:0]      rd_latch,
  output logic [PIN_W-1:0]      en_pd,
  output logic [PIN_W-1:0]      en_pu_strong,
  output logic [PIN_W-1:0]      en_pu_weak,
  output logic [PIN_W-1:0]      en_pu_vweak
);

  logic [PIN_W-1:0] latch_q, mode0_q, mode1_q, pad_sync;

  assign wr_ready = 1'b1;

  gpq_regs #(.PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rst_tristate(rst_tristate),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .latch_q(latch_q), .mode0_q(mode0_q), .mode1_q(mode1_q)
  );

  gpq_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_sync(pad_sync)
  );

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    gpq_pin #(.BOOST_CYC(BOOST_CYC)) u_pin (
      .clk(clk), .rst_n(rst_n),
      .m0(mode0_q[i]), .m1(mode1_q[i]),
      .latch_bit(latch_q[i]), .pad_bit(pad_sync[i]), .vwk_off(vwk_off),
      .en_pd(en_pd[i]), .en_strong(en_pu_strong[i]),
      .en_weak(en_pu_weak[i]), .en_vweak(en_pu_vweak[i])
    );
  end

  assign rd_pins  = pad_sync;
  assign rd_latch = latch_q;

  // R8
  push_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode1_q & ~mode0_q & latch_q) & ~en_pu_strong) == '0);

endmodule

// File: tb/sim_gpq_port.sv
module sim_gpq_port;
  localparam int W = 8;
  localparam int BOOST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_tristate = 1'b1;
  logic vwk_off = 1'b0;
  logic wr_valid = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] pad_in = '1;
  logic wr_ready;
  logic [W-1:0] rd_pins, rd_latch, en_pd, en_pu_strong, en_pu_weak, en_pu_vweak;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  gpq_port u0 (
    .clk(clk), .rst_n(rst_n), .rst_tristate(rst_tristate), .vwk_off(vwk_off),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_in(pad_in), .rd_pins(rd_pins), .rd_latch(rd_latch), .en_pd(en_pd),
    .en_pu_strong(en_pu_strong), .en_pu_weak(en_pu_weak), .en_pu_vweak(en_pu_vweak)
  );

  // behavioural reference state
  bit [W-1:0] m_lat, m_m0, m_m1, m_prev, m_s1, m_s2;
  int m_cnt [W];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = '1; m_m0 = rst_tristate ? '1 : '0; m_m1 = '0;
      m_prev = '1; m_s1 = '0; m_s2 = '0;
      for (int i = 0; i < W; i++) m_cnt[i] = 0;
      cmp_en = 1'b1;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (m_lat[i] && !m_prev[i] && !m_m0[i] && !m_m1[i]) m_cnt[i] = BOOST - 1;
        else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
      end
      m_prev = m_lat;
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (wr_valid) begin
        if (wr_addr == 2'd0) m_lat = wr_data;
        else if (wr_addr == 2'd1) m_m0 = wr_data;
        else if (wr_addr == 2'd2) m_m1 = wr_data;
      end
    end
  end

  function automatic void model_out(output bit [W-1:0] pd, st, wk, vw);
    pd = '0; st = '0; wk = '0; vw = '0;
    for (int i = 0; i < W; i++) begin
      bit q, pp, inp;
      q   = !m_m0[i] && !m_m1[i];
      pp  = !m_m0[i] &&  m_m1[i];
      inp =  m_m0[i] && !m_m1[i];
      pd[i] = !m_lat[i] && !inp;
      vw[i] = q && m_lat[i] && !vwk_off;
      wk[i] = q && m_lat[i] && m_s2[i];
      st[i] = (pp && m_lat[i]) ||
              (q && m_lat[i] && (!m_prev[i] || m_cnt[i] > 0));
    end
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_en) begin
      bit [W-1:0] pd, st, wk, vw;
      model_out(pd, st, wk, vw);
      chk("R2 ready", {7'd0, wr_ready}, 8'd1);
      chk("R10 pins", rd_pins, m_s2);
      chk("R10 latch", rd_latch, m_lat);
      chk("R4/R9 pd", en_pd, pd);
      chk("R7/R8/R9 strong", en_pu_strong, st);
      chk("R6/R9 weak", en_pu_weak, wk);
      chk("R5/R9 vweak", en_pu_vweak, vw);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: input-only reset, latch all ones
    chk("R3 latch", rd_latch, 8'hFF);
    chk("R3 pd", en_pd, 8'h00);
    chk("R3 vweak", en_pu_vweak, 8'h00);

    // R1: all pins quasi-bidirectional
    wr(2'd1, 8'h00);
    cyc(3);
    @(negedge clk);
    chk("R5 vweak all", en_pu_vweak, 8'hFF);
    chk("R6 weak high pad", en_pu_weak, 8'hFF);
    chk("R7 no boost", en_pu_strong, 8'h00);

    pad_in = 8'h0F;
    cyc(1);
    @(negedge clk);
    chk("R6 weak lag", en_pu_weak, 8'hFF);
    cyc(1);
    @(negedge clk);
    chk("R6 weak drop", en_pu_weak, 8'h0F);

    vwk_off = 1'b1;
    #1;
    chk("R5 global off", en_pu_vweak, 8'h00);
    cyc(1);
    vwk_off = 1'b0;

    wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R4 pd", en_pd, 8'hFF);
    cyc(2);
    wr(2'd0, 8'hA5);
    @(negedge clk);
    chk("R7 boost c1", en_pu_strong, 8'hA5);
    @(negedge clk);
    chk("R7 boost c2", en_pu_strong, 8'hA5);
    @(negedge clk);
    chk("R7 boost end", en_pu_strong, 8'h00);

    // R11: spare address has no effect
    wr(2'd3, 8'h00);
    @(negedge clk);
    chk("R11 latch kept", rd_latch, 8'hA5);
    chk("R11 pd kept", en_pd, 8'h5A);

    // R1/R8/R9: mixed modes
    wr(2'd2, 8'hF0);
    wr(2'd1, 8'hCC);
    @(negedge clk);
    chk("R8 push strong", en_pu_strong, 8'h20);
    chk("R9 pd mixed", en_pd, 8'h52);
    chk("R1 vweak quasi only", en_pu_vweak, 8'h01);

    // free-running mix against the reference
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      wr_valid = ($urandom % 3) != 0;
      wr_addr  = 2'($urandom);
      wr_data  = 8'($urandom);
      pad_in   = 8'($urandom);
      vwk_off  = ($urandom % 4) == 0;
      if (wr_valid && wr_addr == 2'd1 && k % 2 == 0) wr_data = 8'h00;
      if (wr_valid && wr_addr == 2'd2 && k % 2 == 0) wr_data = 8'h00;
    end
    wr_valid = 1'b0;

    // R3: quasi-bidirectional reset
    rst_tristate = 1'b0;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    pad_in = 8'hFF;
    vwk_off = 1'b0;
    @(negedge clk);
    chk("R3 quasi vweak", en_pu_vweak, 8'hFF);
    chk("R3 quasi pd", en_pd, 8'h00);
    cyc(4);
    summary();
  end
endmodule